// File: doc/BRIEF.md
# RV64 Integer ALU with Word Operations

This block is the purely combinational integer execute unit of a 64-bit RISC-V style core. Each evaluation takes the first source register value, a second operand, a 4-bit operation code and a word-mode flag, and produces a 64-bit result in the same evaluation. The second operand is either the second source register or a sign-extended 12-bit immediate, selected by an input. The two upper-immediate forms build their result from a 20-bit immediate, and the PC-relative form adds the current program counter to it.

In word mode, add, subtract and the three shifts work on the low 32 bits of the operands. They then copy result bit 31 into the upper half. Word shifts take a 5-bit shift amount, while 64-bit shifts take 6 bits. A word shift given an immediate with bit 5 set is a reserved encoding. For that case the block raises a flag for the decode and trap logic. Decoding instructions, the register file, memory access and pipeline staging are handled elsewhere.

Top module: `rv64_int_alu`

## Requirements
- R1: Operation codes (`op_i`) are 0 add, 1 subtract, 2 signed less-than, 3 unsigned less-than, 4 XOR, 5 OR, 6 AND, 7 left shift, 8 logical right shift, 9 arithmetic right shift, 10 load-upper, 11 PC-relative upper. In 64-bit mode, add and subtract return the low 64 bits of the true result and drop any overflow.
- R2: The two less-than codes return 1 when the first operand is below the second and 0 otherwise. Code 2 compares both as two's-complement values and code 3 compares both as unsigned. Bits 63:1 of the result are always zero.
- R3: When `use_imm_i` is 1, the second operand is `imm12_i` sign-extended to 64 bits. This holds for the unsigned compare as well, so an immediate of 0xFFF compares as the all-ones value.
- R4: XOR, OR and AND act bitwise on the first operand and the selected second operand.
- R5: 64-bit shifts use a 6-bit amount: `rs2_i[5:0]` in register form and `imm12_i[5:0]` in immediate form. Higher bits of the amount source are ignored.
- R6: A 64-bit arithmetic right shift fills the vacated bits with bit 63 of the first operand. A logical right shift fills them with zeros.
- R7: With `word_i` set, add and subtract return the low 32 bits of the sum or difference, sign-extended from bit 31.
- R8: With `word_i` set, shifts act on `rs1_i[31:0]`. The amount is the low 5 bits of its source. The word arithmetic shift fills from bit 31. The 32-bit result is sign-extended from bit 31.
- R9: `illegal_o` is 1 exactly when `word_i`=1, `use_imm_i`=1, the code is one of the shifts (7, 8, 9) and `imm12_i[5]`=1. While it is 1, `result_o` is zero. Register-form word shifts never raise it.
- R10: Code 10 returns `imm20_i` placed in bits 31:12, with zero low bits, sign-extended from bit 31. Code 11 returns `pc_i` plus that same value, modulo 2^64.
- R11: `word_i` has no effect on codes 2 to 6, 10 and 11.
- R12: Codes 12 to 15 return zero and do not raise `illegal_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 4 | Operation code (see R1) |
| word_i | input | 1 | Word mode for add, subtract and shifts |
| use_imm_i | input | 1 | Select sign-extended 12-bit immediate as second operand |
| rs1_i | input | 64 | First source operand |
| rs2_i | input | 64 | Second source register value |
| imm12_i | input | 12 | 12-bit immediate / shift amount field |
| imm20_i | input | 20 | Upper immediate |
| pc_i | input | 64 | Program counter for the PC-relative upper form |
| result_o | output | 64 | Result |
| illegal_o | output | 1 | Reserved word-shift immediate encoding |

## Verification
The bench targets the boundary values where a plausible implementation goes wrong. Add and subtract are driven across the 64-bit and 32-bit wraparound points; a word add that did not sign-extend would leave zeros in the upper half. The tests use shift amounts whose bits above the valid width are set. A shifter that did not mask would produce zero instead of a shifted value, and a word shifter that kept 6 bits would shift by 32 or more. Sign sources are checked as well: a word arithmetic shift must fill from bit 31, not bit 63, and an unsigned immediate compare must sign-extend the immediate before comparing. Finally, the reserved word-shift immediate is applied together with its legal register-form neighbour, which confirms that the flag fires only on the reserved case.

// File: rtl/rv64_alu_pkg.sv
package rv64_alu_pkg;
  typedef enum logic [3:0] {
    OP_ADD   = 4'd0,
    OP_SUB   = 4'd1,
    OP_SLT   = 4'd2,
    OP_SLTU  = 4'd3,
    OP_XOR   = 4'd4,
    OP_OR    = 4'd5,
    OP_AND   = 4'd6,
    OP_SLL   = 4'd7,
    OP_SRL   = 4'd8,
    OP_SRA   = 4'd9,
    OP_LUI   = 4'd10,
    OP_AUIPC = 4'd11
  } alu_op_e;
endpackage

// File: rtl/rv64_alu_operand.sv
module rv64_alu_operand #(
  parameter int XLEN = 64,
  parameter int ILEN = 12,
  parameter int ULEN = 20,
  localparam int SHW = $clog2(XLEN)
) (
  input  logic [XLEN-1:0] rs2_i,
  input  logic [ILEN-1:0] imm12_i,
  input  logic [ULEN-1:0] imm20_i,
  input  logic            use_imm_i,
  output logic [XLEN-1:0] opb_o,
  output logic [SHW-1:0]  shamt_o,
  output logic [XLEN-1:0] upper_o
);
  localparam int UPOS = 32 - ULEN;

  logic [31:0] upper32;

  assign opb_o   = use_imm_i ? {{(XLEN-ILEN){imm12_i[ILEN-1]}}, imm12_i} : rs2_i;
  assign shamt_o = use_imm_i ? imm12_i[SHW-1:0] : rs2_i[SHW-1:0];
  assign upper32 = {imm20_i, {UPOS{1'b0}}};
  assign upper_o = {{(XLEN-32){upper32[31]}}, upper32};
endmodule

// File: rtl/rv64_alu_arith.sv
module rv64_alu_arith #(
  parameter int XLEN = 64,
  parameter int WLEN = 32
) (
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  input  logic            sub_i,
  input  logic            word_i,
  output logic [XLEN-1:0] sum_o,
  output logic            lt_o,
  output logic            ltu_o
);
  logic [XLEN-1:0] b_eff;
  logic [XLEN-1:0] raw;

  assign b_eff = sub_i ? ~b_i : b_i;
  assign raw   = a_i + b_eff + {{(XLEN-1){1'b0}}, sub_i};
  assign sum_o = word_i ? {{(XLEN-WLEN){raw[WLEN-1]}}, raw[WLEN-1:0]} : raw;
  assign lt_o  = $signed(a_i) < $signed(b_i);
  assign ltu_o = a_i < b_i;
endmodule

// File: rtl/rv64_alu_shifter.sv
module rv64_alu_shifter #(
  parameter int XLEN = 64,
  parameter int WLEN = 32,
  localparam int SHW  = $clog2(XLEN),
  localparam int WSHW = $clog2(WLEN)
) (
  input  logic [XLEN-1:0] src_i,
  input  logic [SHW-1:0]  shamt_i,
  input  logic            left_i,
  input  logic            arith_i,
  input  logic            word_i,
  output logic [XLEN-1:0] res_o
);
  logic [XLEN-1:0] full_res;
  logic [XLEN-1:0] wsrc;
  logic [XLEN-1:0] wshift;
  logic [WSHW-1:0] wamt;

  always_comb begin
    if (left_i)       full_res = src_i << shamt_i;
    else if (arith_i) full_res = $signed(src_i) >>> shamt_i;
    else              full_res = src_i >> shamt_i;
  end

  // word path: widen low half with sign or zero so one right shifter serves both
  assign wamt = shamt_i[WSHW-1:0];
  assign wsrc = arith_i ? {{(XLEN-WLEN){src_i[WLEN-1]}}, src_i[WLEN-1:0]}
                        : {{(XLEN-WLEN){1'b0}}, src_i[WLEN-1:0]};

  always_comb begin
    if (left_i)       wshift = wsrc << wamt;
    else if (arith_i) wshift = $signed(wsrc) >>> wamt;
    else              wshift = wsrc >> wamt;
  end

  assign res_o = word_i ? {{(XLEN-WLEN){wshift[WLEN-1]}}, wshift[WLEN-1:0]} : full_res;
endmodule

// File: rtl/rv64_int_alu.sv
module rv64_int_alu
  import rv64_alu_pkg::*;
#(
  parameter int XLEN = 64,
  parameter int WLEN = 32,
  parameter int ILEN = 12,
  parameter int ULEN = 20
) (
  input  logic [3:0]      op_i,
  input  logic            word_i,
  input  logic            use_imm_i,
  input  logic [XLEN-1:0] rs1_i,
  input  logic [XLEN-1:0] rs2_i,
  input  logic [ILEN-1:0] imm12_i,
  input  logic [ULEN-1:0] imm20_i,
  input  logic [XLEN-1:0] pc_i,
  output logic [XLEN-1:0] result_o,
  output logic            illegal_o
);
  localparam int SHW  = $clog2(XLEN);
  localparam int WSHW = $clog2(WLEN);

  alu_op_e         op;
  logic [XLEN-1:0] opb, upper, add_a, add_b, sum, shres;
  logic [SHW-1:0]  shamt;
  logic            lt, ltu, is_shift, is_auipc, add_word;

  assign op       = alu_op_e'(op_i);
  assign is_shift = (op == OP_SLL) || (op == OP_SRL) || (op == OP_SRA);
  assign is_auipc = (op == OP_AUIPC);

  rv64_alu_operand #(.XLEN(XLEN), .ILEN(ILEN), .ULEN(ULEN)) u_operand (
    .rs2_i    (rs2_i),
    .imm12_i  (imm12_i),
    .imm20_i  (imm20_i),
    .use_imm_i(use_imm_i),
    .opb_o    (opb),
    .shamt_o  (shamt),
    .upper_o  (upper)
  );

  // one adder serves add/sub and the PC-relative upper form
  assign add_a    = is_auipc ? pc_i  : rs1_i;
  assign add_b    = is_auipc ? upper : opb;
  assign add_word = word_i && !is_auipc;

  rv64_alu_arith #(.XLEN(XLEN), .WLEN(WLEN)) u_arith (
    .a_i   (add_a),
    .b_i   (add_b),
    .sub_i (op == OP_SUB),
    .word_i(add_word),
    .sum_o (sum),
    .lt_o  (lt),
    .ltu_o (ltu)
  );

  rv64_alu_shifter #(.XLEN(XLEN), .WLEN(WLEN)) u_shifter (
    .src_i  (rs1_i),
    .shamt_i(shamt),
    .left_i (op == OP_SLL),
    .arith_i(op == OP_SRA),
    .word_i (word_i),
    .res_o  (shres)
  );

  // reserved: word shift immediate with amount bit beyond the word range
  assign illegal_o = word_i && use_imm_i && is_shift && imm12_i[WSHW];

  always_comb begin
    result_o = '0;
    if (!illegal_o) begin
      unique case (op)
        OP_ADD, OP_SUB, OP_AUIPC: result_o = sum;
        OP_SLT:                   result_o = {{(XLEN-1){1'b0}}, lt};
        OP_SLTU:                  result_o = {{(XLEN-1){1'b0}}, ltu};
        OP_XOR:                   result_o = rs1_i ^ opb;
        OP_OR:                    result_o = rs1_i | opb;
        OP_AND:                   result_o = rs1_i & opb;
        OP_SLL, OP_SRL, OP_SRA:   result_o = shres;
        OP_LUI:                   result_o = upper;
        default:                  result_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/rv64_int_alu_chk.sv
module rv64_int_alu_chk #(
  parameter int XLEN = 64,
  parameter int ILEN = 12,
  parameter int ULEN = 20
) (
  input logic [3:0]      op_i,
  input logic            word_i,
  input logic            use_imm_i,
  input logic [XLEN-1:0] rs1_i,
  input logic [XLEN-1:0] rs2_i,
  input logic [ILEN-1:0] imm12_i,
  input logic [ULEN-1:0] imm20_i,
  input logic [XLEN-1:0] pc_i,
  input logic [XLEN-1:0] result_o,
  input logic            illegal_o
);
  logic word_arith;
  assign word_arith = word_i && (op_i == 4'd0 || op_i == 4'd1 || op_i == 4'd7 ||
                                 op_i == 4'd8 || op_i == 4'd9);

  always_comb begin
    // R2
    cmp_bool_chk: assert (!(op_i == 4'd2 || op_i == 4'd3) || result_o[XLEN-1:1] == '0);
    // R2
    cmp_irreflexive_chk: assert (!(op_i == 4'd2 && !use_imm_i && rs1_i == rs2_i) || result_o == '0);
    // R7
    word_sext_chk: assert (!word_arith || result_o[XLEN-1:31] == '0 || result_o[XLEN-1:31] == '1);
    // R9
    illegal_cond_chk: assert (!illegal_o || (word_i && use_imm_i && imm12_i[5] &&
                                             op_i >= 4'd7 && op_i <= 4'd9));
    // R9
    illegal_zero_chk: assert (!illegal_o || result_o == '0);
    // R10
    lui_field_chk: assert (op_i != 4'd10 || (result_o[11:0] == '0 && result_o[31:12] == imm20_i));
    // R10
    auipc_low_chk: assert (op_i != 4'd11 || result_o[11:0] == pc_i[11:0]);
    // R12
    unused_op_chk: assert (op_i < 4'd12 || (result_o == '0 && !illegal_o));
  end
endmodule

bind rv64_int_alu rv64_int_alu_chk #(.XLEN(XLEN), .ILEN(ILEN), .ULEN(ULEN)) u_chk (.*);

// File: tb/rv64_int_alu_tb.sv
module rv64_int_alu_tb;
  logic        clk = 1'b0;
  logic [3:0]  op_i = '0;
  logic        word_i = 1'b0, use_imm_i = 1'b0;
  logic [63:0] rs1_i = '0, rs2_i = '0, pc_i = '0;
  logic [11:0] imm12_i = '0;
  logic [19:0] imm20_i = '0;
  logic [63:0] result_o;
  logic        illegal_o;
  int          n_tests = 0, n_fail = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  rv64_int_alu u_dut (
    .op_i(op_i), .word_i(word_i), .use_imm_i(use_imm_i), .rs1_i(rs1_i), .rs2_i(rs2_i),
    .imm12_i(imm12_i), .imm20_i(imm20_i), .pc_i(pc_i), .result_o(result_o), .illegal_o(illegal_o)
  );

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(logic [3:0] op, logic w, logic ui, logic [63:0] a, logic [63:0] b,
                       logic [11:0] i12, logic [19:0] i20 = '0, logic [63:0] pc = '0);
    @(negedge clk);
    op_i = op; word_i = w; use_imm_i = ui; rs1_i = a; rs2_i = b;
    imm12_i = i12; imm20_i = i20; pc_i = pc;
    #5;
  endtask

  task automatic t_idle;
    drive(4'd0, 0, 0, 0, 0, 0);
    check("R1 idle result", result_o, 64'h0);
    check("R9 idle flag", {63'h0, illegal_o}, 64'h0);
  endtask

  task automatic t_addsub;
    drive(4'd0, 0, 0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1, 0);
    check("R1 add wrap", result_o, 64'h0);
    drive(4'd1, 0, 0, 64'h0, 64'h1, 0);
    check("R1 sub wrap", result_o, 64'hFFFF_FFFF_FFFF_FFFF);
  endtask

  task automatic t_compare;
    drive(4'd2, 0, 0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1, 0);
    check("R2 slt signed", result_o, 64'h1);
    drive(4'd3, 0, 0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1, 0);
    check("R2 sltu unsigned", result_o, 64'h0);
    drive(4'd2, 0, 0, 64'h5, 64'h5, 0);
    check("R2 slt equal", result_o, 64'h0);
  endtask

  task automatic t_imm;
    drive(4'd0, 0, 1, 64'd10, 64'h77, 12'hFFF);
    check("R3 addi negative", result_o, 64'd9);
    drive(4'd3, 0, 1, 64'd5, 64'h0, 12'hFFF);
    check("R3 sltiu sext", result_o, 64'h1);
    drive(4'd2, 0, 1, 64'd5, 64'h0, 12'hFFF);
    check("R3 slti", result_o, 64'h0);
  endtask

  task automatic t_logic;
    drive(4'd4, 0, 0, 64'hF0F0, 64'hFF00, 0);
    check("R4 xor", result_o, 64'h0FF0);
    drive(4'd5, 0, 0, 64'hF0F0, 64'hFF00, 0);
    check("R4 or", result_o, 64'hFFF0);
    drive(4'd6, 0, 0, 64'hF0F0, 64'hFF00, 0);
    check("R4 and", result_o, 64'hF000);
    drive(4'd4, 0, 1, 64'h0, 64'h0, 12'hFFF);
    check("R4 xori invert", result_o, 64'hFFFF_FFFF_FFFF_FFFF);
  endtask

  task automatic t_shift64;
    drive(4'd7, 0, 0, 64'h1, 64'hFFFF_FFFF_FFFF_FFFF, 0);
    check("R5 sll mask 63", result_o, 64'h8000_0000_0000_0000);
    drive(4'd7, 0, 0, 64'h1, 64'h40, 0);
    check("R5 sll amount 64 masks to 0", result_o, 64'h1);
    drive(4'd8, 0, 1, 64'h8000_0000_0000_0000, 0, 12'h03F);
    check("R5 srli 63", result_o, 64'h1);
    drive(4'd9, 0, 0, 64'h8000_0000_0000_0000, 64'd4, 0);
    check("R6 sra fill", result_o, 64'hF800_0000_0000_0000);
    drive(4'd8, 0, 0, 64'h8000_0000_0000_0000, 64'd4, 0);
    check("R6 srl zero fill", result_o, 64'h0800_0000_0000_0000);
  endtask

  task automatic t_word_arith;
    drive(4'd0, 1, 0, 64'h7FFF_FFFF, 64'h1, 0);
    check("R7 addw sext", result_o, 64'hFFFF_FFFF_8000_0000);
    drive(4'd1, 1, 0, 64'h1_0000_0000, 64'h1, 0);
    check("R7 subw", result_o, 64'hFFFF_FFFF_FFFF_FFFF);
    drive(4'd0, 1, 0, 64'hABCD_0000_0000_0005, 64'h3, 0);
    check("R7 addw drops upper", result_o, 64'h8);
  endtask

  task automatic t_word_shift;
    drive(4'd7, 1, 0, 64'h1, 64'd63, 0);
    check("R8 sllw mask 31", result_o, 64'hFFFF_FFFF_8000_0000);
    drive(4'd7, 1, 0, 64'h1, 64'd32, 0);
    check("R8 sllw amount 32 masks to 0", result_o, 64'h1);
    drive(4'd8, 1, 0, 64'hFFFF_FFFF_8000_0000, 64'd4, 0);
    check("R8 srlw", result_o, 64'h0000_0000_0800_0000);
    drive(4'd9, 1, 0, 64'h0000_0000_8000_0000, 64'd4, 0);
    check("R8 sraw bit31 sign", result_o, 64'hFFFF_FFFF_F800_0000);
    drive(4'd9, 1, 1, 64'h0000_0001_4000_0000, 0, 12'h001);
    check("R8 sraiw positive", result_o, 64'h2000_0000);
  endtask

  task automatic t_illegal;
    drive(4'd9, 1, 1, 64'h8000_0000_0000_0000, 0, 12'h021);
    check("R9 flag reserved", {63'h0, illegal_o}, 64'h1);
    check("R9 zero result", result_o, 64'h0);
    drive(4'd9, 0, 1, 64'h8000_0000_0000_0000, 0, 12'h021);
    check("R9 no flag 64-bit", {63'h0, illegal_o}, 64'h0);
    check("R9 srai 33", result_o, 64'hFFFF_FFFF_C000_0000);
    drive(4'd7, 1, 0, 64'h3, 64'h21, 0);
    check("R9 no flag register form", {63'h0, illegal_o}, 64'h0);
    check("R9 sllw reg 33->1", result_o, 64'h6);
    drive(4'd7, 1, 1, 64'h1, 0, 12'h01F);
    check("R9 no flag slliw 31", {63'h0, illegal_o}, 64'h0);
  endtask

  task automatic t_upper;
    drive(4'd10, 0, 0, 0, 0, 0, 20'h80000);
    check("R10 lui sext", result_o, 64'hFFFF_FFFF_8000_0000);
    drive(4'd10, 0, 0, 0, 0, 0, 20'h12345);
    check("R10 lui", result_o, 64'h1234_5000);
    drive(4'd11, 0, 0, 0, 0, 0, 20'h00001, 64'h1000);
    check("R10 auipc", result_o, 64'h2000);
    drive(4'd11, 0, 0, 0, 0, 0, 20'hFFFFF, 64'h1_0000_0000);
    check("R10 auipc negative", result_o, 64'hFFFF_F000);
  endtask

  task automatic t_word_ignored;
    drive(4'd4, 1, 0, 64'hFFFF_FFFF_0000_0000, 64'h0, 0);
    check("R11 xor word ignored", result_o, 64'hFFFF_FFFF_0000_0000);
    drive(4'd3, 1, 0, 64'h1_0000_0000, 64'hFFFF_FFFF, 0);
    check("R11 sltu word ignored", result_o, 64'h0);
    drive(4'd10, 1, 0, 0, 0, 0, 20'h12345);
    check("R11 lui word ignored", result_o, 64'h1234_5000);
    drive(4'd11, 1, 0, 0, 0, 0, 20'h00001, 64'h0000_0001_7FFF_F000);
    check("R11 auipc word ignored", result_o, 64'h0000_0001_8000_0000);
  endtask

  task automatic t_unused;
    drive(4'd13, 1, 1, 64'hFFFF, 64'hFFFF, 12'h021);
    check("R12 unused result", result_o, 64'h0);
    check("R12 unused flag", {63'h0, illegal_o}, 64'h0);
  endtask

  initial begin
    t_idle();
    t_addsub();
    t_compare();
    t_imm();
    t_logic();
    t_shift64();
    t_word_arith();
    t_word_shift();
    t_illegal();
    t_upper();
    t_word_ignored();
    t_unused();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule